// File: doc/BRIEF.md
# Memory-Module Presence EEPROM Bus Target

This block is the two-wire serial target that sits on a memory module and hands the host the module's description bytes. It watches a clock line and a data line shared by up to eight modules. It pulls the data line low only through an open-drain enable. Three strap pins give the module its slot number. The storage is 512 bytes, split into two pages of 256 bytes. Only the selected page is reachable through normal reads and writes. Each page is further divided into two 128-byte blocks, and each of the four blocks has its own write lock.

The host reads in one of two ways. It can write a one-byte offset, issue a repeated START and then read. It can also read from wherever the internal pointer was left. In both cases it keeps reading for as long as it acknowledges. Writes carry an offset followed by any number of data bytes.

A few broadcast addresses switch the visible page or set and clear the block locks, and every module answers these whatever its slot. Any address that is not decoded is left unacknowledged. This includes the on-module temperature sensor range, which this block does not implement.

The block runs from a faster system clock. It resynchronises both bus lines and acts on the detected edges.

Top module: `spd_presence_target`

## Requirements
- R1: After reset the data line is released, page 0 is selected, all four block locks are clear and every stored byte reads 0x00.
- R2: The data-access device-select byte is prefix 1010 in bits 7..4, the slot pins in bits 3..1 and read (1) or write (0) in bit 0, so the 7-bit address is 0x50 plus the slot. The block acknowledges only its own slot.
- R3: A write-direction select to 7-bit address 0x36 selects page 0 and one to 0x37 selects page 1. The block acknowledges both on every slot.
- R4: Data reads and writes reach only the selected page, so offset k of page 0 and offset k of page 1 are separate bytes.
- R5: In a write, the first byte after the select is the offset and each later byte is stored at the pointer. Every byte is acknowledged.
- R6: A read returns the byte at the pointer and continues with the next byte while the host acknowledges. After the host's NACK the block stops driving.
- R7: The pointer advances by one per byte read or written and wraps from 0xFF to 0x00 inside the selected page, never reaching the other page.
- R8: A write-direction select to 0x30+b (b = 0..3) locks block b, where block = page*2 + offset bit 7, and a write-direction select to 0x34 clears all locks, on every slot. A data byte aimed at a locked block is acknowledged but the stored byte keeps its old value.
- R9: Undecoded addresses are not acknowledged. These include 0x18..0x1F, 0x35, another slot's data address, and the read direction on any command address.
- R10: After a command address has been acknowledged, further bytes of the same transfer are not acknowledged.
- R11: A STOP releases the data line and ends the transfer. The block changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| slot_i | input | 3 | Slot strap pins giving the low three address bits |
| sda_oe_o | output | 1 | When high, the data line is pulled low |

## Verification
A wrong pointer, page or lock bit stays hidden until the next data byte crosses the bus. It then shows up as a wrong byte in the read that follows. The bench therefore pairs every write with a read-back, including across the page boundary and after a wrap, and it re-reads the page that should be untouched. A broken bit counter or acknowledge sequencer shows up within one byte time as a missing or spurious acknowledge. A drive change while the clock is high shows up on the very clock it happens, and the bench watches for it on every system clock.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam logic [3:0] DATA_PREFIX = 4'b1010;
    localparam logic [6:0] CMD_PAGE0   = 7'h36;
    localparam logic [6:0] CMD_PAGE1   = 7'h37;
    localparam logic [6:0] CMD_UNLOCK  = 7'h34;
    localparam logic [4:0] LOCK_STEM   = 5'b01100;  // 0x30..0x33

    typedef enum logic [2:0] {
        DEC_NONE,
        DEC_DATA,
        DEC_PAGE0,
        DEC_PAGE1,
        DEC_LOCK,
        DEC_UNLOCK
    } sel_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_OFFS,
        PH_DATA
    } rx_phase_e;

    typedef enum logic [1:0] {
        NX_IDLE,
        NX_OFFS,
        NX_DATA,
        NX_SEND
    } after_ack_e;

endpackage

// File: rtl/spd_line_sampler.sv
module spd_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);

    logic [STAGES-1:0] scl_sync_q;
    logic [STAGES-1:0] sda_sync_q;
    logic              scl_prev_q;
    logic              sda_prev_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[STAGES-2:0], scl_i};
            sda_sync_q <= {sda_sync_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sync_q[STAGES-1];
            sda_prev_q <= sda_sync_q[STAGES-1];
        end
    end

    assign scl_s    = scl_sync_q[STAGES-1];
    assign sda_s    = sda_sync_q[STAGES-1];
    assign ev_rise  = scl_s & ~scl_prev_q;
    assign ev_fall  = ~scl_s & scl_prev_q;
    assign ev_start = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign ev_stop  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/spd_select_decode.sv
module spd_select_decode
    import spd_pkg::*;
(
    input  logic [7:0] sel_byte,
    input  logic [2:0] slot,
    output sel_kind_e  kind,
    output logic [1:0] lock_blk,
    output logic       is_read
);

    logic [6:0] addr7;

    assign addr7    = sel_byte[7:1];
    assign is_read  = sel_byte[0];
    assign lock_blk = addr7[1:0];

    always_comb begin
        kind = DEC_NONE;
        if (addr7 == {DATA_PREFIX, slot}) begin
            kind = DEC_DATA;
        end else if (!is_read) begin
            if (addr7 == CMD_PAGE0) begin
                kind = DEC_PAGE0;
            end else if (addr7 == CMD_PAGE1) begin
                kind = DEC_PAGE1;
            end else if (addr7 == CMD_UNLOCK) begin
                kind = DEC_UNLOCK;
            end else if (addr7[6:2] == LOCK_STEM) begin
                kind = DEC_LOCK;
            end
        end
    end

endmodule

// File: rtl/spd_byte_store.sv
module spd_byte_store #(
    parameter int DEPTH = 512,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/spd_presence_target.sv
module spd_presence_target
    import spd_pkg::*;
#(
    parameter int PAGE_BYTES      = 256,
    parameter int NUM_PAGES       = 2,
    parameter int BLOCKS_PER_PAGE = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] slot_i,
    output logic       sda_oe_o
);

    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int PAGE_W     = $clog2(NUM_PAGES);
    localparam int ADDR_W     = OFF_W + PAGE_W;
    localparam int MEM_DEPTH  = NUM_PAGES * PAGE_BYTES;
    localparam int NUM_BLOCKS = NUM_PAGES * BLOCKS_PER_PAGE;
    localparam int SUB_W      = $clog2(BLOCKS_PER_PAGE);
    localparam int BLK_W      = PAGE_W + SUB_W;

    typedef struct packed {
        bus_state_e            st;
        rx_phase_e             ph;
        after_ack_e            nxt;
        logic [3:0]            cnt;
        logic [7:0]            shr;
        logic [7:0]            txr;
        logic [OFF_W-1:0]      ptr;
        logic [PAGE_W-1:0]     page;
        logic [NUM_BLOCKS-1:0] lock;
        logic                  macked;
        logic                  oe;
    } core_t;

    core_t cur_q, nxt_d;

    logic              sda_s, ev_rise, ev_fall, ev_start, ev_stop;
    sel_kind_e         sel_kind;
    logic [1:0]        sel_blk;
    logic              sel_rd;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_byte;
    logic [BLK_W-1:0]  wr_blk;
    logic [PAGE_W-1:0] page_now;

    spd_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    spd_select_decode u_decode (
        .sel_byte (cur_q.shr),
        .slot     (slot_i),
        .kind     (sel_kind),
        .lock_blk (sel_blk),
        .is_read  (sel_rd)
    );

    spd_byte_store #(.DEPTH(MEM_DEPTH), .AW(ADDR_W), .DW(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr ({cur_q.page, cur_q.ptr}),
        .rdata (rd_byte)
    );

    assign wr_blk   = {cur_q.page, cur_q.ptr[OFF_W-1 -: SUB_W]};
    assign page_now = cur_q.page;
    assign sda_oe_o = cur_q.oe;

    always_comb begin
        nxt_d     = cur_q;
        mem_we    = 1'b0;
        mem_waddr = {cur_q.page, cur_q.ptr};
        mem_wdata = cur_q.shr;
        if (ev_stop) begin
            nxt_d.st = ST_IDLE;
            nxt_d.oe = 1'b0;
        end else if (ev_start) begin
            nxt_d.st  = ST_RECV;
            nxt_d.ph  = PH_ADDR;
            nxt_d.cnt = '0;
            nxt_d.oe  = 1'b0;
        end else begin
            unique case (cur_q.st)
                ST_RECV: begin
                    if (ev_rise && cur_q.cnt != 4'd8) begin
                        nxt_d.shr = {cur_q.shr[6:0], sda_s};
                        nxt_d.cnt = cur_q.cnt + 4'd1;
                    end else if (ev_fall && cur_q.cnt == 4'd8) begin
                        nxt_d.st = ST_ACK;
                        nxt_d.oe = 1'b1;
                        unique case (cur_q.ph)
                            PH_ADDR: begin
                                nxt_d.nxt = NX_IDLE;
                                case (sel_kind)
                                    DEC_DATA:   nxt_d.nxt = sel_rd ? NX_SEND : NX_OFFS;
                                    DEC_PAGE0:  nxt_d.page = '0;
                                    DEC_PAGE1:  nxt_d.page = PAGE_W'(1);
                                    DEC_LOCK:   nxt_d.lock[sel_blk] = 1'b1;
                                    DEC_UNLOCK: nxt_d.lock = '0;
                                    default: begin
                                        nxt_d.st = ST_IDLE;
                                        nxt_d.oe = 1'b0;
                                    end
                                endcase
                            end
                            PH_OFFS: begin
                                nxt_d.ptr = cur_q.shr[OFF_W-1:0];
                                nxt_d.nxt = NX_DATA;
                            end
                            default: begin
                                mem_we    = !cur_q.lock[wr_blk];
                                nxt_d.ptr = cur_q.ptr + OFF_W'(1);
                                nxt_d.nxt = NX_DATA;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev_fall) begin
                        nxt_d.oe  = 1'b0;
                        nxt_d.cnt = '0;
                        unique case (cur_q.nxt)
                            NX_OFFS: begin
                                nxt_d.st = ST_RECV;
                                nxt_d.ph = PH_OFFS;
                            end
                            NX_DATA: begin
                                nxt_d.st = ST_RECV;
                                nxt_d.ph = PH_DATA;
                            end
                            NX_SEND: begin
                                nxt_d.st  = ST_SEND;
                                nxt_d.txr = rd_byte;
                                nxt_d.oe  = ~rd_byte[7];
                                nxt_d.ptr = cur_q.ptr + OFF_W'(1);
                            end
                            default: nxt_d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_SEND: begin
                    if (ev_fall) begin
                        if (cur_q.cnt == 4'd7) begin
                            nxt_d.st = ST_MACK;
                            nxt_d.oe = 1'b0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 4'd1;
                            nxt_d.txr = {cur_q.txr[6:0], 1'b0};
                            nxt_d.oe  = ~cur_q.txr[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_rise) begin
                        nxt_d.macked = ~sda_s;
                    end else if (ev_fall) begin
                        if (cur_q.macked) begin
                            nxt_d.st  = ST_SEND;
                            nxt_d.cnt = '0;
                            nxt_d.txr = rd_byte;
                            nxt_d.oe  = ~rd_byte[7];
                            nxt_d.ptr = cur_q.ptr + OFF_W'(1);
                        end else begin
                            nxt_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/spd_presence_checks.sv
module spd_presence_checks #(
    parameter int PAGE_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              ev_fall,
    input logic              ev_start,
    input logic              ev_stop,
    input logic [PAGE_W-1:0] page,
    input logic              mem_we
);

    // R11: drive changes only follow a detected low-going clock or a bus condition
    a_r11_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(ev_fall || ev_start || ev_stop));

    // R11: the line is free right after a STOP
    a_r11_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe);

    // R3: page moves only at the end of a received byte
    a_r3_page_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page) |-> $past(ev_fall));

    // R5: array writes happen only on a clock falling edge
    a_r5_store_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ev_fall);

endmodule

bind spd_presence_target spd_presence_checks #(.PAGE_W(PAGE_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .page     (page_now),
    .mem_we   (mem_we)
);

// File: tb/spd_presence_target_test.sv
module spd_presence_target_test;

    localparam int Q = 8;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] slot  = 3'b010;
    logic       sda_oe;
    wire        sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    spd_presence_target uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .slot_i   (slot),
        .sda_oe_o (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    int mon_err = 0;
    bit finished = 1'b0;

    byte unsigned ref_mem [512];
    int           ref_page = 0;
    bit [3:0]     ref_lock = '0;
    int           ref_ptr  = 0;

    // drive may not move while the clock has been high for two samples
    logic mon_scl_q = 1'b1;
    logic mon_oe_q  = 1'b0;
    always @(posedge clk) begin
        if (rst_n && m_scl && mon_scl_q && (sda_oe !== mon_oe_q)) mon_err++;
        mon_scl_q <= m_scl;
        mon_oe_q  <= sda_oe;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q_wait();
        m_scl = 1'b1; q_wait();
        m_sda = 1'b0; q_wait();
        m_scl = 1'b0; q_wait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q_wait();
        m_scl = 1'b1; q_wait();
        m_sda = 1'b1; q_wait();
    endtask

    task automatic put_bit(bit b);
        m_sda = b;    q_wait();
        m_scl = 1'b1; q_wait(); q_wait();
        m_scl = 1'b0; q_wait();
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1'b1; q_wait();
        m_scl = 1'b1; q_wait();
        b = sda_line; q_wait();
        m_scl = 1'b0; q_wait();
    endtask

    task automatic send_byte(input bit [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output bit [7:0] v, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    function automatic bit [7:0] dev(bit rd);
        return {4'b1010, slot, rd};
    endfunction

    task automatic do_write(int off, byte unsigned data[$], string req);
        bit ack;
        bus_start();
        send_byte(dev(1'b0), ack);
        check(ack, "R2", ack, 1);
        send_byte(8'(off), ack);
        check(ack, "R5", ack, 1);
        ref_ptr = off;
        foreach (data[k]) begin
            send_byte(data[k], ack);
            check(ack, req, ack, 1);
            if (!ref_lock[ref_page * 2 + ref_ptr / 128]) ref_mem[ref_page * 256 + ref_ptr] = data[k];
            ref_ptr = (ref_ptr + 1) % 256;
        end
        bus_stop();
    endtask

    task automatic do_read(int off, int n, string req);
        bit ack;
        bit [7:0] v;
        bus_start();
        send_byte(dev(1'b0), ack);
        check(ack, "R2", ack, 1);
        send_byte(8'(off), ack);
        check(ack, "R6", ack, 1);
        ref_ptr = off;
        bus_start();
        send_byte(dev(1'b1), ack);
        check(ack, "R6", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k != n - 1);
            check(v == ref_mem[ref_page * 256 + ref_ptr], req, v, ref_mem[ref_page * 256 + ref_ptr]);
            ref_ptr = (ref_ptr + 1) % 256;
        end
        check(sda_oe == 1'b0, "R6", sda_oe, 0);
        bus_stop();
        repeat (4) @(negedge clk);
        check(sda_oe == 1'b0, "R11", sda_oe, 0);
    endtask

    task automatic do_cmd(bit [6:0] a, string req);
        bit ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(ack, req, ack, 1);
        if (a == 7'h36) ref_page = 0;
        else if (a == 7'h37) ref_page = 1;
        else if (a == 7'h34) ref_lock = '0;
        else if (a[6:2] == 5'b01100) ref_lock[a[1:0]] = 1'b1;
        bus_stop();
    endtask

    task automatic expect_nack(bit [7:0] sel, string req);
        bit ack;
        bus_start();
        send_byte(sel, ack);
        check(!ack, req, ack, 0);
        q_wait();
        check(sda_oe == 1'b0, req, sda_oe, 0);
        bus_stop();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit ack;
        foreach (ref_mem[i]) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1: released line and cleared array on page 0
        check(sda_oe == 1'b0, "R1", sda_oe, 0);
        do_read(8'h00, 2, "R1");

        // R5, R6: burst write then sequential and random reads
        do_write(8'h10, '{8'h11, 8'h22, 8'h33, 8'hC4}, "R5");
        do_read(8'h10, 4, "R6");
        do_read(8'h12, 1, "R6");

        // R2, R9: another slot's address and undecoded ranges
        expect_nack({4'b1010, 3'b101, 1'b0}, "R2");
        expect_nack({7'h1A, 1'b0}, "R9");
        expect_nack({7'h35, 1'b0}, "R9");
        expect_nack({7'h36, 1'b1}, "R9");
        expect_nack({7'h31, 1'b1}, "R9");

        // R10: extra byte after a page command is refused
        bus_start();
        send_byte({7'h37, 1'b0}, ack);
        check(ack, "R3", ack, 1);
        ref_page = 1;
        send_byte(8'h5A, ack);
        check(!ack, "R10", ack, 0);
        bus_stop();

        // R4: page 1 holds its own bytes
        do_write(8'h10, '{8'hA5}, "R4");
        do_cmd(7'h36, "R3");
        do_read(8'h10, 1, "R4");
        do_cmd(7'h37, "R3");
        do_read(8'h10, 2, "R4");

        // R3: page commands from a different slot
        slot = 3'b000;
        do_cmd(7'h36, "R3");
        do_read(8'h11, 1, "R3");

        // R7: wrap inside page 1, page 0 untouched
        do_cmd(7'h37, "R3");
        do_write(8'hFE, '{8'h01, 8'h02, 8'h03}, "R7");
        do_read(8'hFE, 3, "R7");
        do_cmd(7'h36, "R3");
        do_read(8'h00, 1, "R7");
        do_read(8'hFF, 2, "R7");

        // R8: lock upper half of page 0
        slot = 3'b111;
        do_cmd(7'h31, "R8");
        do_write(8'h7F, '{8'h5A, 8'h6B}, "R8");
        do_read(8'h7F, 2, "R8");
        do_cmd(7'h37, "R3");
        do_write(8'h80, '{8'h77}, "R8");
        do_read(8'h80, 1, "R8");
        do_cmd(7'h36, "R3");
        do_cmd(7'h34, "R8");
        do_write(8'h80, '{8'h99}, "R8");
        do_read(8'h7F, 2, "R8");

        repeat (20) @(negedge clk);
        check(mon_err == 0, "R11", mon_err, 0);
        report();
    end

endmodule